// File: doc/BRIEF.md
# Serial Symbol Deserializer with Boundary Alignment

This block sits on the receive side of a serial link, after clock recovery. It takes the recovered bit stream one bit at a time, qualified by a bit enable, and assembles the bits into parallel symbols. The symbols are 10 bits wide for raw line code or 8 bits wide for byte transport. It also produces a byte clock that keeps a fixed phase relation to each new symbol. A small set of configuration inputs controls the receiver. These inputs enable the receiver, optionally invert the polarity of the incoming bits, select the parallel width, and choose how the symbol boundary is found.

There are three boundary modes. In the first, nothing moves the boundary. In the second, the boundary locks onto any comma character that arrives off the current boundary. In the third, the boundary slips by a single bit when software raises the upper mode bit. A reserved configuration code raises an error flag. It does not corrupt the stream: the width stays at its last good value and alignment behaves as off.

Top module: `serial_symbol_deser`

## Requirements
- R1: While `rxEnable` is 0, `symOut` reads zero and `byteClk` is low from the next clock onward, and the bit counter is cleared. The first bit taken with `bitEn` after enabling is the first bit of a new symbol.
- R2: Bits fill each symbol in arrival order: the first received bit lands in `symOut[0]`. `symOut` updates on the clock edge that takes the last bit of the symbol, and `byteClk` goes high on that same edge.
- R3: In 10-bit width (`widthCode` 000), a symbol completes every 10 taken bits. `byteClk` is high for the first 4 of those bit times and low for the other 6.
- R4: In 8-bit width (`widthCode` 001), a byte completes every 8 taken bits on `symOut[7:0]`, with `byteClk` high for 4 bit times and low for 4. `symOut[9:8]` carries bits [1:0] of the byte output before it. A width change takes effect one clock after the code is applied.
- R5: With `invertPol` at 1, every received bit is complemented before comma search and assembly.
- R6: With `alignMode` 01, the bit counter holds a window of the last 10 bits, oldest at bit 0. When that window matches a comma that ends off the current boundary, the window is output at once as a symbol and the next bit starts a new symbol. A comma is the arrival sequence 0011111010 (window value 0x17C) or 1100000101 (window value 0x283).
- R7: With `alignMode` 00, commas never move the boundary. Switching from any mode to 00 leaves the boundary where it was.
- R8: A taken bit on which `alignMode` is 10 while the upper mode bit was 0 on the previous taken bit does not advance the counter and ends no symbol, so the boundary slips one bit later. Holding 10 slips only once.
- R9: `cfgErr` is 1 one clock after a reserved `widthCode` (any value other than 000 or 001) or `alignMode` 11 is applied. A reserved width keeps the last valid width, and `alignMode` 11 performs no alignment.
- R10: On a clock with `bitEn` at 0, `serIn` is ignored, no bit is counted and `symOut` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Qualifies `serIn` as a new received bit |
| serIn | input | 1 | Recovered serial data bit |
| rxEnable | input | 1 | Receiver enable |
| invertPol | input | 1 | Complement incoming bits |
| alignMode | input | 2 | 00 off, 01 comma lock, 10 one-bit slip, 11 reserved |
| widthCode | input | 3 | 000 ten-bit, 001 eight-bit, others reserved |
| symOut | output | 10 | Parallel symbol |
| byteClk | output | 1 | Symbol clock, high in the first 4 bit times |
| cfgErr | output | 1 | Reserved configuration code seen |

## Verification
The bit slip and the end of a symbol can fall on the same taken bit. The bench provokes this by raising the slip mode exactly on the tenth bit of a symbol. The held counter must then emit nothing on that bit and deliver the symbol one bit later. A comma that completes on the boundary itself is the second overlap: it must be treated as an ordinary symbol end. Random streams with injected commas at arbitrary offsets and stalled bit enables reach this case, and the bench judges each clock against a reference computed from the requirements.

// File: rtl/serial_symbol_deser_pkg.sv
package serial_symbol_deser_pkg;

  typedef enum logic [1:0] {
    ALIGN_OFF   = 2'b00,
    ALIGN_COMMA = 2'b01,
    ALIGN_JOG   = 2'b10,
    ALIGN_RSVD  = 2'b11
  } align_mode_e;

  localparam logic [2:0] WIDTH_TEN   = 3'b000;
  localparam logic [2:0] WIDTH_EIGHT = 3'b001;

  // comma window values, oldest received bit at position 0
  localparam logic [9:0] COMMA_NEG = 10'h17C;
  localparam logic [9:0] COMMA_POS = 10'h283;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic shift;
    logic emit;
    logic wide;
  } deser_strobe_t;

endpackage

// File: rtl/serial_symbol_deser_ctrl.sv
module serial_symbol_deser_ctrl
  import serial_symbol_deser_pkg::*;
#(
  parameter int SYM_W     = 10,
  parameter int BYTE_W    = 8,
  parameter int HIGH_BITS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  logic          rxEnable,
  input  logic [1:0]    alignMode,
  input  logic [2:0]    widthCode,
  input  logic          commaHit,
  output deser_strobe_t strobe,
  output logic          byteClk,
  output logic          cfgErr
);
  localparam int CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(SYM_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] HIGH_CNT    = CNT_W'(HIGH_BITS);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic wideQ, prevHi, activeQ;
  logic widthOk, alignOk, jogHit, commaMode, atEnd, realign;

  always_comb begin
    widthOk   = (widthCode == WIDTH_TEN) || (widthCode == WIDTH_EIGHT);
    alignOk   = (alignMode != ALIGN_RSVD);
    lastIdx   = wideQ ? LAST_WIDE : LAST_NARROW;
    atEnd     = (bitCnt >= lastIdx);
    commaMode = (alignMode == ALIGN_COMMA);
    jogHit    = (alignMode == ALIGN_JOG) && !prevHi;
    realign   = commaMode && commaHit && !atEnd;

    strobe.clear = !rxEnable;
    strobe.shift = rxEnable && bitEn;
    strobe.emit  = rxEnable && bitEn && !jogHit && (atEnd || realign);
    strobe.wide  = wideQ;

    byteClk = activeQ && (bitCnt < HIGH_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      wideQ   <= 1'b1;
      prevHi  <= 1'b0;
      activeQ <= 1'b0;
      cfgErr  <= 1'b0;
    end else begin
      activeQ <= rxEnable;
      cfgErr  <= !widthOk || !alignOk;
      if (widthOk) wideQ <= (widthCode == WIDTH_TEN);
      if (bitEn) prevHi <= alignMode[1];
      if (!rxEnable) begin
        bitCnt <= '0;
      end else if (bitEn && !jogHit) begin
        if (atEnd || realign) bitCnt <= '0;
        else                  bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_symbol_deser_dp.sv
module serial_symbol_deser_dp
  import serial_symbol_deser_pkg::*;
#(
  parameter int SYM_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             invertPol,
  input  deser_strobe_t    strobe,
  output logic             commaHit,
  output logic [SYM_W-1:0] symOut
);
  localparam int CARRY = SYM_W - BYTE_W;

  logic             bitIn;
  logic [SYM_W-1:0] win;
  logic [SYM_W-1:0] nextWin;

  always_comb begin
    bitIn    = serIn ^ invertPol;
    nextWin  = {bitIn, win[SYM_W-1:1]};
    commaHit = (nextWin == COMMA_NEG) || (nextWin == COMMA_POS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win    <= '0;
      symOut <= '0;
    end else if (strobe.clear) begin
      win    <= '0;
      symOut <= '0;
    end else if (strobe.shift) begin
      win <= nextWin;
      if (strobe.emit) begin
        if (strobe.wide) symOut <= nextWin;
        else             symOut <= {symOut[CARRY-1:0], nextWin[SYM_W-1:CARRY]};
      end
    end
  end

endmodule

// File: rtl/serial_symbol_deser.sv
module serial_symbol_deser
  import serial_symbol_deser_pkg::*;
#(
  parameter int SYM_W     = 10,
  parameter int BYTE_W    = 8,
  parameter int HIGH_BITS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             serIn,
  input  logic             rxEnable,
  input  logic             invertPol,
  input  logic [1:0]       alignMode,
  input  logic [2:0]       widthCode,
  output logic [SYM_W-1:0] symOut,
  output logic             byteClk,
  output logic             cfgErr
);
  deser_strobe_t strobe;
  logic          commaHit;

  serial_symbol_deser_ctrl #(
    .SYM_W(SYM_W), .BYTE_W(BYTE_W), .HIGH_BITS(HIGH_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxEnable(rxEnable),
    .alignMode(alignMode), .widthCode(widthCode), .commaHit(commaHit),
    .strobe(strobe), .byteClk(byteClk), .cfgErr(cfgErr)
  );

  serial_symbol_deser_dp #(
    .SYM_W(SYM_W), .BYTE_W(BYTE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .serIn(serIn), .invertPol(invertPol),
    .strobe(strobe), .commaHit(commaHit), .symOut(symOut)
  );

endmodule

// File: rtl/serial_symbol_deser_chk.sv
module serial_symbol_deser_chk #(
  parameter int SYM_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitEn,
  input logic             rxEnable,
  input logic [1:0]       alignMode,
  input logic [2:0]       widthCode,
  input logic [SYM_W-1:0] symOut,
  input logic             byteClk,
  input logic             cfgErr
);
  localparam int CARRY = SYM_W - BYTE_W;

  // R1: disabled receiver shows zero symbol and low byte clock
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (symOut == '0 && !byteClk));

  // R10: no taken bit, no symbol change
  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && !bitEn) |=> $stable(symOut));

  // R9: reserved width code flags an error
  a_r9_width_rsvd_flag: assert property (@(posedge clk) disable iff (!rstN)
    (widthCode > 3'd1) |=> cfgErr);

  // R9: reserved alignment code flags an error
  a_r9_align_rsvd_flag: assert property (@(posedge clk) disable iff (!rstN)
    (alignMode == 2'b11) |=> cfgErr);

  // R4: in 8-bit width the upper bits carry the low bits of the previous byte
  a_r4_upper_carry: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && $past(rstN) && widthCode == 3'd1 && $past(widthCode) == 3'd1)
      |=> ($stable(symOut) ||
           symOut[SYM_W-1:BYTE_W] == $past(symOut[CARRY-1:0])));

endmodule

bind serial_symbol_deser serial_symbol_deser_chk #(
  .SYM_W(SYM_W), .BYTE_W(BYTE_W)
) chk_i (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxEnable(rxEnable),
  .alignMode(alignMode), .widthCode(widthCode), .symOut(symOut),
  .byteClk(byteClk), .cfgErr(cfgErr)
);

// File: tb/serial_symbol_deser_tb.sv
module serial_symbol_deser_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic serIn = 1'b0;
  logic rxEnable = 1'b0;
  logic invertPol = 1'b0;
  logic [1:0] alignMode = 2'b00;
  logic [2:0] widthCode = 3'b000;
  logic [9:0] symOut;
  logic byteClk, cfgErr;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit chkOn = 1'b0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_symbol_deser dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .serIn(serIn),
    .rxEnable(rxEnable), .invertPol(invertPol), .alignMode(alignMode),
    .widthCode(widthCode), .symOut(symOut), .byteClk(byteClk), .cfgErr(cfgErr)
  );

  // reference state derived from the requirements
  logic [9:0] mWin, mSym, mNew;
  logic [3:0] mCnt;
  logic mWide, mPrev, mAct, mErr, mAtEnd, mJog, mRe, mHit;

  always @(posedge clk) begin
    if (!rstN) begin
      mWin = '0; mSym = '0; mCnt = '0; mWide = 1'b1; mPrev = 1'b0;
      mAct = 1'b0; mErr = 1'b0;
    end else begin
      mAtEnd = mCnt >= (mWide ? 4'd9 : 4'd7);
      mNew   = {serIn ^ invertPol, mWin[9:1]};
      mHit   = (mNew == 10'h17C) || (mNew == 10'h283);
      mJog   = (alignMode == 2'b10) && !mPrev;
      mRe    = (alignMode == 2'b01) && mHit && !mAtEnd;
      if (!rxEnable) begin
        mWin = '0; mSym = '0; mCnt = '0;
      end else if (bitEn) begin
        mWin = mNew;
        if (!mJog) begin
          if (mAtEnd || mRe) begin
            mSym = mWide ? mNew : {mSym[1:0], mNew[9:2]};
            mCnt = '0;
          end else begin
            mCnt = mCnt + 4'd1;
          end
        end
      end
      if (bitEn) mPrev = alignMode[1];
      if (widthCode < 3'd2) mWide = (widthCode == 3'd0);
      mErr = (widthCode > 3'd1) || (alignMode == 2'b11);
      mAct = rxEnable;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      check(curReq, "symOut", 32'(symOut), 32'(mSym));
      check(curReq, "byteClk", 32'(byteClk), 32'(mAct && (mCnt < 4'd4)));
      check(curReq, "cfgErr", 32'(cfgErr), 32'(mErr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic tick(input logic b, input logic en);
    serIn = b; bitEn = en;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic restart();
    rxEnable = 1'b0; tick(1'b0, 1'b1); rxEnable = 1'b1;
  endtask

  task automatic sendSym(input logic [9:0] v, input int n);
    for (int i = 0; i < n; i++) tick(v[i], 1'b1);
  endtask

  task automatic randomRun(input int n, input int pEn, input bit commas);
    for (int i = 0; i < n; i++) begin
      if (commas && ($urandom % 40) == 0)
        sendSym(($urandom % 2) ? 10'h17C : 10'h283, 10);
      else
        tick(1'($urandom), ($urandom % 100) < pEn);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "reset symOut", 32'(symOut), 0);
    check("R1", "reset byteClk", 32'(byteClk), 0);
    check("R1", "reset cfgErr", 32'(cfgErr), 0);
    chkOn = 1'b1;

    // R2: ordering of one known symbol
    curReq = "R2";
    restart();
    sendSym(10'h2A5, 10);
    check("R2", "first symbol", 32'(symOut), 32'h2A5);
    check("R2", "byteClk with symbol", 32'(byteClk), 1);

    // R3: byte clock shape in 10-bit width
    curReq = "R3";
    restart();
    for (int i = 1; i <= 20; i++) begin
      tick(1'($urandom), 1'b1);
      check("R3", "byteClk phase", 32'(byteClk), 32'((i % 10) < 4));
    end
    randomRun(300, 100, 1'b0);

    // R10: stalls inside a symbol
    curReq = "R10";
    restart();
    for (int i = 0; i < 10; i++) begin
      repeat (3) tick(1'($urandom), 1'b0);
      tick(i[0] ? 1'b0 : 1'b1, 1'b1);
    end
    check("R10", "stalled symbol", 32'(symOut), 32'h155);
    randomRun(400, 60, 1'b0);

    // R4: 8-bit width and carried bits
    curReq = "R4";
    widthCode = 3'b001;
    restart();
    sendSym(10'h0C3, 8);
    check("R4", "first byte", 32'(symOut), 32'h0C3);
    sendSym(10'h05A, 8);
    check("R4", "carried bits", 32'(symOut), 32'h35A);
    restart();
    for (int i = 1; i <= 16; i++) begin
      tick(1'($urandom), 1'b1);
      check("R4", "byteClk phase", 32'(byteClk), 32'((i % 8) < 4));
    end
    randomRun(400, 80, 1'b0);
    widthCode = 3'b000;

    // R5: polarity inversion
    curReq = "R5";
    invertPol = 1'b1;
    restart();
    sendSym(~10'h2A5, 10);
    check("R5", "inverted symbol", 32'(symOut), 32'h2A5);
    randomRun(300, 90, 1'b0);
    invertPol = 1'b0;

    // R6: comma lock at an off-boundary offset
    curReq = "R6";
    alignMode = 2'b01;
    restart();
    tick(1'b1, 1'b1); tick(1'b0, 1'b1); tick(1'b1, 1'b1);
    sendSym(10'h17C, 10);
    check("R6", "comma output", 32'(symOut), 32'h17C);
    sendSym(10'h2A5, 10);
    check("R6", "aligned data", 32'(symOut), 32'h2A5);
    // R7: leaving comma mode for off keeps the boundary
    alignMode = 2'b00;
    sendSym(10'h0F3, 10);
    check("R7", "boundary kept", 32'(symOut), 32'h0F3);
    alignMode = 2'b01;
    randomRun(800, 85, 1'b1);
    invertPol = 1'b1;
    randomRun(400, 85, 1'b1);
    invertPol = 1'b0;
    widthCode = 3'b001;
    randomRun(400, 85, 1'b1);
    widthCode = 3'b000;

    // R7: off mode ignores an off-boundary comma
    curReq = "R7";
    alignMode = 2'b00;
    restart();
    tick(1'b1, 1'b1); tick(1'b0, 1'b1); tick(1'b1, 1'b1);
    sendSym(10'h17C, 10);
    check("R7", "no realign", 32'(symOut), 32'h3E5);
    randomRun(300, 85, 1'b1);

    // R8: slip on the first bit, then held mode slips no more
    curReq = "R8";
    restart();
    alignMode = 2'b10;
    tick(1'b1, 1'b1);
    sendSym(10'h2A5, 9);
    check("R8", "no symbol before slip end", 32'(symOut), 0);
    tick(1'b1, 1'b1);
    check("R8", "slipped symbol", 32'(symOut), 32'h2A5);
    sendSym(10'h15A, 10);
    check("R8", "single slip", 32'(symOut), 32'h15A);
    // R8: slip falls on the last bit of a symbol
    alignMode = 2'b00;
    restart();
    tick(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) begin
      if (i == 8) alignMode = 2'b10;
      tick(10'h0F3 >> i, 1'b1);
      if (i == 8) check("R8", "held at boundary", 32'(symOut), 0);
    end
    check("R8", "late symbol", 32'(symOut), 32'h0F3);
    for (int k = 0; k < 12; k++) begin
      alignMode = 2'($urandom);
      if (alignMode == 2'b11) alignMode = 2'b10;
      randomRun(40, 90, 1'b1);
    end

    // R9: reserved width keeps 8-bit timing and flags
    curReq = "R9";
    alignMode = 2'b00;
    widthCode = 3'b001;
    restart();
    widthCode = 3'b010;
    for (int i = 1; i <= 16; i++) begin
      tick(1'($urandom), 1'b1);
      check("R9", "byteClk kept 8-bit", 32'(byteClk), 32'((i % 8) < 4));
      check("R9", "width flag", 32'(cfgErr), 1);
    end
    widthCode = 3'b000;
    // R9: reserved alignment does nothing
    alignMode = 2'b11;
    restart();
    tick(1'b1, 1'b1); tick(1'b0, 1'b1); tick(1'b1, 1'b1);
    sendSym(10'h17C, 10);
    check("R9", "reserved align no realign", 32'(symOut), 32'h3E5);
    check("R9", "align flag", 32'(cfgErr), 1);
    alignMode = 2'b01;

    // R1: random enable drops
    curReq = "R1";
    for (int k = 0; k < 20; k++) begin
      rxEnable = ($urandom % 4) != 0;
      randomRun(30, 80, 1'b1);
    end
    rxEnable = 1'b0;
    tick(1'b1, 1'b1);
    check("R1", "disabled symOut", 32'(symOut), 0);
    check("R1", "disabled byteClk", 32'(byteClk), 0);

    chkOn = 1'b0;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule